// File: doc/BRIEF.md
# Read-Priority Shared Memory Arbiter

This block decides which of several processor agents may use one shared memory port. Each agent has a read request and a write request. The block answers each agent with a read grant and a write grant. Any number of agents can read at the same time. Only one agent can write at a time, and a write never overlaps a read. An agent keeps its grant until it pulses its done line.

The block publishes the state of the memory as one of three codes: idle, writing or reading. Reads take precedence. A writer is admitted only from idle. A read phase that is already running accepts late readers. When a write finishes, any readers that were waiting start before any waiting writer. When several writers compete, they take turns in round-robin order.

Top module: `shmem_rdpri_arbiter`

## Requirements
- R1: After reset, every read and write grant is low and the status output reads idle, encoded 2'b00. The writing code is 2'b01 and the reading code is 2'b10.
- R2: At most one write grant is high at any time, and a write grant is never high in the same cycle as any read grant.
- R3: The status is writing whenever a write grant is held. It is reading whenever one or more read grants are held. It is idle when no grant is held.
- R4: A write grant is only issued on the clock edge that follows a cycle in which the status was idle. Write requests raised during a write or read phase are held off.
- R5: In an idle cycle with read requests pending, every pending reader is granted at the next edge and no writer is granted at that edge.
- R6: During a read phase, an agent that raises a read request is granted at the next edge. A pending write request is not granted while any read grant is held.
- R7: On the edge where the active writer's done is sampled, all readers that are pending in that cycle are granted together and the status moves straight to reading.
- R8: In an idle cycle with only write requests pending, exactly one writer is granted at the next edge. The search starts at the agent after the last one granted a write, wrapping from the highest index to 0. After reset the search starts at agent 0.
- R9: A done pulse from an agent that holds no grant leaves all grants and the status unchanged.
- R10: An agent that asserts read and write requests together is treated as a reader.
- R11: A grant stays high until its agent's done is sampled, and it is low from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | N | Per-agent read request (level) |
| wrReq | input | N | Per-agent write request (level) |
| done | input | N | Per-agent completion pulse |
| rdGnt | output | N | Per-agent read grant |
| wrGnt | output | N | Per-agent write grant |
| memState | output | 2 | Memory status: 00 idle, 01 writing, 10 reading |

## Verification
The bench sweeps all 256 combinations of read and write requests for four agents, starting from idle. It checks that reads win whenever any reader is present, and that the lone writer chosen follows the rotating pointer it tracks itself. A design with a fixed-priority pick, or one that admits a writer next to readers, fails this sweep. Directed sequences cover the handover from writer to waiting readers, a reader joining an active phase while a writer waits, a done pulse from an idle agent, and an agent that asserts both requests. A design that detoured through idle after a write, let a writer in early, or dropped a grant on a stray done pulse would show the wrong grants at the next sample.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    MEM_IDLE  = 2'b00,
    MEM_WRITE = 2'b01,
    MEM_READ  = 2'b10
  } memStatusT;

  // Strobes from control to datapath
  typedef struct packed {
    logic grantReads;
    logic grantWrite;
  } arbStrobeT;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyPendRd,
  input  logic      anyPendWr,
  input  logic      anyKeepRd,
  input  logic      anyKeepWr,
  output arbStrobeT strb,
  output memStatusT status
);
  memStatusT statusNext;

  always_comb begin
    strb = '0;
    unique case (status)
      MEM_IDLE: begin
        strb.grantReads = anyPendRd;
        strb.grantWrite = !anyPendRd && anyPendWr;
      end
      MEM_WRITE: begin
        // readers take over as soon as the writer is released
        strb.grantReads = !anyKeepWr && anyPendRd;
      end
      MEM_READ: begin
        strb.grantReads = anyPendRd;
      end
      default: strb = '0;
    endcase
  end

  always_comb begin
    if (strb.grantWrite || anyKeepWr)
      statusNext = MEM_WRITE;
    else if (strb.grantReads || anyKeepRd)
      statusNext = MEM_READ;
    else
      statusNext = MEM_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) status <= MEM_IDLE;
    else       status <= statusNext;
  end
endmodule

// File: rtl/arb_dpath.sv
module arb_dpath
  import arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] rdReq,
  input  logic [N-1:0] wrReq,
  input  logic [N-1:0] done,
  input  arbStrobeT    strb,
  output logic         anyPendRd,
  output logic         anyPendWr,
  output logic         anyKeepRd,
  output logic         anyKeepWr,
  output logic [N-1:0] rdGnt,
  output logic [N-1:0] wrGnt
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     keepRd, keepWr, freeAgent, pendRd, pendWr, pickOh;
  logic [IDX_W-1:0] lastWr, pickIdx;

  assign keepRd    = rdGnt & ~done;
  assign keepWr    = wrGnt & ~done;
  assign freeAgent = ~(rdGnt | wrGnt);
  assign pendRd    = rdReq & freeAgent;
  assign pendWr    = wrReq & ~rdReq & freeAgent;   // read wins per agent

  assign anyPendRd = |pendRd;
  assign anyPendWr = |pendWr;
  assign anyKeepRd = |keepRd;
  assign anyKeepWr = |keepWr;

  // rotating pick, searching from the agent after the last writer
  always_comb begin
    logic found;
    found   = 1'b0;
    pickOh  = '0;
    pickIdx = lastWr;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(lastWr) + k) % N;
      if (!found && pendWr[idx]) begin
        found       = 1'b1;
        pickOh[idx] = 1'b1;
        pickIdx     = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdGnt  <= '0;
      wrGnt  <= '0;
      lastWr <= IDX_W'(N - 1);
    end else begin
      rdGnt <= keepRd | (strb.grantReads ? pendRd : '0);
      wrGnt <= keepWr | (strb.grantWrite ? pickOh : '0);
      if (strb.grantWrite) lastWr <= pickIdx;
    end
  end
endmodule

// File: rtl/shmem_rdpri_arbiter.sv
module shmem_rdpri_arbiter
  import arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] rdReq,
  input  logic [N-1:0] wrReq,
  input  logic [N-1:0] done,
  output logic [N-1:0] rdGnt,
  output logic [N-1:0] wrGnt,
  output logic [1:0]   memState
);
  arbStrobeT strb;
  memStatusT status;
  logic      anyPendRd, anyPendWr, anyKeepRd, anyKeepWr;

  arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .anyPendRd(anyPendRd), .anyPendWr(anyPendWr),
    .anyKeepRd(anyKeepRd), .anyKeepWr(anyKeepWr),
    .strb(strb), .status(status)
  );

  arb_dpath #(.N(N)) u_dpath (
    .clk(clk), .rstN(rstN),
    .rdReq(rdReq), .wrReq(wrReq), .done(done), .strb(strb),
    .anyPendRd(anyPendRd), .anyPendWr(anyPendWr),
    .anyKeepRd(anyKeepRd), .anyKeepWr(anyKeepWr),
    .rdGnt(rdGnt), .wrGnt(wrGnt)
  );

  assign memState = status;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] done,
  input logic [N-1:0] rdGnt,
  input logic [N-1:0] wrGnt,
  input logic [1:0]   memState
);
  // R2
  one_writer_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(wrGnt) <= 1) && !((|wrGnt) && (|rdGnt)));

  // R3
  status_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|wrGnt) ? memState == 2'b01 : (|rdGnt) ? memState == 2'b10 : memState == 2'b00));

  // R4
  write_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((wrGnt & ~$past(wrGnt)) != '0) |-> $past(memState) == 2'b00);

  // R6
  no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rdGnt) |=> (wrGnt & ~$past(wrGnt)) == '0);

  // R11
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdGnt | wrGnt) & ~done) != '0 |=>
      ((($past(rdGnt) & ~$past(done)) & ~rdGnt) == '0) &&
      ((($past(wrGnt) & ~$past(done)) & ~wrGnt) == '0));

  // R11
  grant_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdGnt | wrGnt) & done) != '0 |=>
      ((($past(rdGnt) | $past(wrGnt)) & $past(done)) & (rdGnt | wrGnt)) == '0);
endmodule

bind shmem_rdpri_arbiter arb_chk #(.N(N)) u_chk (
  .clk(clk), .rstN(rstN), .done(done),
  .rdGnt(rdGnt), .wrGnt(wrGnt), .memState(memState)
);

// File: tb/sim_shmem_rdpri_arbiter.sv
`timescale 1ns/1ps
module sim_shmem_rdpri_arbiter;
  localparam int N = 4;
  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] rdReq = '0, wrReq = '0, done = '0;
  logic [N-1:0] rdGnt, wrGnt;
  logic [1:0]   memState;
  int tests = 0, fails = 0;
  int lastW = N - 1;

  always #2 clk = ~clk;   // 250 MHz

  shmem_rdpri_arbiter #(.N(N)) u0 (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .done(done),
    .rdGnt(rdGnt), .wrGnt(wrGnt), .memState(memState)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect3(string req, logic [N-1:0] eRd, logic [N-1:0] eWr, logic [1:0] eSt);
    tests++;
    if (rdGnt !== eRd || wrGnt !== eWr || memState !== eSt) begin
      fails++;
      $display("FAIL %s: rd=%b wr=%b st=%b expected rd=%b wr=%b st=%b",
               req, rdGnt, wrGnt, memState, eRd, eWr, eSt);
    end
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    expect3("R1 reset", '0, '0, 2'b00);
    rstN = 1'b1;
    step();
    expect3("R1 after reset", '0, '0, 2'b00);

    // Exhaustive sweep from idle: R5, R8, R10, R11
    for (int r = 0; r < 16; r++) begin
      for (int w = 0; w < 16; w++) begin
        logic [N-1:0] pw, oh;
        rdReq = N'(r); wrReq = N'(w);
        pw = N'(w) & ~N'(r);
        oh = '0;
        if (r == 0 && pw != 0) begin
          for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (lastW + k) % N;
            if (oh == 0 && pw[idx]) begin oh[idx] = 1'b1; lastW = idx; end
          end
        end
        step();
        if (r != 0)       expect3("R5/R10 reads first", N'(r), '0, 2'b10);
        else if (pw != 0) expect3("R8 round-robin writer", '0, oh, 2'b01);
        else              expect3("R9 idle no request", '0, '0, 2'b00);
        rdReq = '0; wrReq = '0; done = '1;
        step();
        done = '0;
        expect3("R11 release on done", '0, '0, 2'b00);
      end
    end

    // Directed: handover, join, stray done
    wrReq = 4'b0001;                // single writer, idle
    step();
    expect3("R8 lone writer", '0, 4'b0001, 2'b01);
    rdReq = 4'b0110; wrReq = 4'b1001;
    step();
    expect3("R4 held during write", '0, 4'b0001, 2'b01);
    done = 4'b0001; wrReq = 4'b1000;
    step();
    done = '0;
    expect3("R7 readers after write", 4'b0110, '0, 2'b10);
    rdReq = 4'b0111;
    step();
    expect3("R6 join read phase", 4'b0111, '0, 2'b10);
    done = 4'b1000;
    step();
    done = '0;
    expect3("R9 stray done ignored", 4'b0111, '0, 2'b10);
    rdReq = '0; done = 4'b0111;
    step();
    done = '0;
    expect3("R4 idle before writer", '0, '0, 2'b00);
    step();
    expect3("R8 writer from idle", '0, 4'b1000, 2'b01);
    wrReq = '0; done = 4'b1000;
    step();
    done = '0;
    expect3("R11 writer released", '0, '0, 2'b00);
    rdReq = 4'b0010; wrReq = 4'b0010;
    step();
    expect3("R10 both requests read", 4'b0010, '0, 2'b10);
    rdReq = '0; wrReq = '0; done = 4'b0010;
    step();
    done = '0;
    expect3("R3 back to idle", '0, '0, 2'b00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule